// File: doc/BRIEF.md
# Sprite-over-Background Pixel Compositor with Palette Lookup

This block sits at the end of a tile-based video pipeline. On every pixel clock it receives the background layer's colour index and palette select. It also receives, for each foreground sprite, a hit flag, a colour index and a palette select. All of these arrive already aligned by the upstream background and sprite units.

The block picks the single winning pixel. Sprites always cover the background, and among sprites the lowest-numbered one whose pixel is opaque wins. The winner's palette and index then address a small writable colour RAM that returns a 12-bit RGB colour. That colour goes out beside delayed copies of the data-enable and sync strobes, so a 320x240 VGA-style scan sees colour and timing in step.

The colour RAM holds 8 palettes of 8 entries. The host fills it through a simple write port. A reset clears every entry to black. The path from inputs to colour output is two clocks, well inside the half-pixel budget of a system clock that runs about 18 times faster than the pixel rate.

Top module: `comp_top`

## Requirements
- R1: Among sprites whose hit flag is set and whose colour index is non-zero, the one with the lowest sprite number supplies the pixel.
- R2: A sprite with its hit flag set but colour index 0 is transparent and is skipped, so a higher-numbered opaque sprite or the background shows through.
- R3: When no sprite is opaque, the background pixel is used, and background colour index 0 is an ordinary colour rather than transparency.
- R4: An opaque sprite always covers the background, whatever the background index or palette.
- R5: The colour RAM address is palette*8 + colour index. A stored word drives red from bits 11:8, green from bits 7:4 and blue from bits 3:0.
- R6: A host write with the write strobe high stores the data at the given address, and any lookup presented on a later clock returns it.
- R7: After reset every colour RAM entry reads as 0 (black).
- R8: While the delayed data-enable output is low, all colour outputs are 0.
- R9: Colour, data-enable and both sync outputs follow their inputs by exactly two clocks.
- R10: Address and data on the host port while the write strobe is low change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bg_cidx | input | 3 | Background colour index |
| bg_pal | input | 3 | Background palette select |
| spr_hit | input | 8 | Per-sprite coverage flag, bit i for sprite i |
| spr_cidx | input | 24 | Per-sprite colour index, sprite i in bits 3i+2:3i |
| spr_pal | input | 24 | Per-sprite palette select, sprite i in bits 3i+2:3i |
| de_in | input | 1 | Active-area flag aligned with the pixel inputs |
| hsync_in | input | 1 | Horizontal sync aligned with the pixel inputs |
| vsync_in | input | 1 | Vertical sync aligned with the pixel inputs |
| pal_we | input | 1 | Host colour RAM write strobe |
| pal_waddr | input | 6 | Host write address (palette*8 + index) |
| pal_wdata | input | 12 | Host write data, R in 11:8, G in 7:4, B in 3:0 |
| red_out | output | 4 | Red channel |
| grn_out | output | 4 | Green channel |
| blu_out | output | 4 | Blue channel |
| de_out | output | 1 | Data-enable delayed to match colour |
| hsync_out | output | 1 | Horizontal sync delayed to match colour |
| vsync_out | output | 1 | Vertical sync delayed to match colour |

## Verification
The assertions assume that the upstream units present sprite and background fields for the same pixel in the same cycle, and that the strobes are valid from the first clock after reset. They compare the delayed strobes with the inputs of two clocks earlier only after two clocks have passed since reset. The bench changes every input on the falling edge, so each pixel and strobe value is stable across the rising edge that captures it. Host writes are kept to cycles in which the written entry is not also being looked up.

// File: rtl/comp_pkg.sv
package comp_pkg;

    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
    } vid_ctl_t;

    localparam vid_ctl_t CTL_IDLE = '{de: 1'b0, hs: 1'b0, vs: 1'b0};

endpackage

// File: rtl/comp_select.sv
module comp_select #(
    parameter int NUM_SPR = 8,
    parameter int CIDX_W  = 3,
    parameter int PAL_W   = 3,
    localparam int ADDR_W = PAL_W + CIDX_W
) (
    input  logic [CIDX_W-1:0]         bg_cidx,
    input  logic [PAL_W-1:0]          bg_pal,
    input  logic [NUM_SPR-1:0]        spr_hit,
    input  logic [NUM_SPR*CIDX_W-1:0] spr_cidx,
    input  logic [NUM_SPR*PAL_W-1:0]  spr_pal,
    output logic                      sel_sprite,
    output logic [ADDR_W-1:0]         sel_addr
);

    logic [NUM_SPR-1:0] opaque;

    for (genvar i = 0; i < NUM_SPR; i++) begin : g_opaque
        assign opaque[i] = spr_hit[i] && (spr_cidx[i*CIDX_W +: CIDX_W] != '0);
    end

    // Scan from the top down so the lowest opaque sprite is written last.
    always_comb begin
        sel_sprite = 1'b0;
        sel_addr   = {bg_pal, bg_cidx};
        for (int i = NUM_SPR - 1; i >= 0; i--) begin
            if (opaque[i]) begin
                sel_sprite = 1'b1;
                sel_addr   = {spr_pal[i*PAL_W +: PAL_W], spr_cidx[i*CIDX_W +: CIDX_W]};
            end
        end
    end

endmodule

// File: rtl/comp_pal_ram.sv
module comp_pal_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 12,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
        // Read sees the contents before this edge's write; blanked when disabled.
        rd_d = rd_en ? mem_q[rd_addr] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
            rd_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/comp_top.sv
module comp_top #(
    parameter int NUM_SPR = 8,
    parameter int CIDX_W  = 3,
    parameter int PAL_W   = 3,
    parameter int CH_W    = 4,
    localparam int ADDR_W = PAL_W + CIDX_W,
    localparam int COL_W  = 3 * CH_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CIDX_W-1:0]         bg_cidx,
    input  logic [PAL_W-1:0]          bg_pal,
    input  logic [NUM_SPR-1:0]        spr_hit,
    input  logic [NUM_SPR*CIDX_W-1:0] spr_cidx,
    input  logic [NUM_SPR*PAL_W-1:0]  spr_pal,
    input  logic                      de_in,
    input  logic                      hsync_in,
    input  logic                      vsync_in,
    input  logic                      pal_we,
    input  logic [ADDR_W-1:0]         pal_waddr,
    input  logic [COL_W-1:0]          pal_wdata,
    output logic [CH_W-1:0]           red_out,
    output logic [CH_W-1:0]           grn_out,
    output logic [CH_W-1:0]           blu_out,
    output logic                      de_out,
    output logic                      hsync_out,
    output logic                      vsync_out
);

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        comp_pkg::vid_ctl_t ctl;
    } stage_t;

    logic              sel_sprite;
    logic [ADDR_W-1:0] sel_addr;
    stage_t            stg_d, stg_q;
    comp_pkg::vid_ctl_t out_d, out_q;
    logic [COL_W-1:0]  rgb;

    comp_select #(
        .NUM_SPR (NUM_SPR),
        .CIDX_W  (CIDX_W),
        .PAL_W   (PAL_W)
    ) u_select (
        .bg_cidx    (bg_cidx),
        .bg_pal     (bg_pal),
        .spr_hit    (spr_hit),
        .spr_cidx   (spr_cidx),
        .spr_pal    (spr_pal),
        .sel_sprite (sel_sprite),
        .sel_addr   (sel_addr)
    );

    always_comb begin
        stg_d.addr   = sel_addr;
        stg_d.ctl.de = de_in;
        stg_d.ctl.hs = hsync_in;
        stg_d.ctl.vs = vsync_in;
        out_d        = stg_q.ctl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '{addr: '0, ctl: comp_pkg::CTL_IDLE};
            out_q <= comp_pkg::CTL_IDLE;
        end else begin
            stg_q <= stg_d;
            out_q <= out_d;
        end
    end

    comp_pal_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (COL_W)
    ) u_pal_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pal_we),
        .wr_addr (pal_waddr),
        .wr_data (pal_wdata),
        .rd_en   (stg_q.ctl.de),
        .rd_addr (stg_q.addr),
        .rd_data (rgb)
    );

    assign red_out   = rgb[COL_W-1 -: CH_W];
    assign grn_out   = rgb[2*CH_W-1 -: CH_W];
    assign blu_out   = rgb[CH_W-1:0];
    assign de_out    = out_q.de;
    assign hsync_out = out_q.hs;
    assign vsync_out = out_q.vs;

endmodule

// File: rtl/comp_top_chk.sv
module comp_top_chk #(
    parameter int CIDX_W = 3,
    parameter int PAL_W  = 3,
    parameter int CH_W   = 4,
    localparam int ADDR_W = PAL_W + CIDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CIDX_W-1:0] bg_cidx,
    input logic [PAL_W-1:0]  bg_pal,
    input logic              de_in,
    input logic              hsync_in,
    input logic              vsync_in,
    input logic [CH_W-1:0]   red_out,
    input logic [CH_W-1:0]   grn_out,
    input logic [CH_W-1:0]   blu_out,
    input logic              de_out,
    input logic              hsync_out,
    input logic              vsync_out,
    input logic              sel_sprite,
    input logic [ADDR_W-1:0] sel_addr
);

    logic [1:0] live_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_cnt_q <= '0;
        end else if (live_cnt_q != 2'd2) begin
            live_cnt_q <= live_cnt_q + 2'd1;
        end
    end

    // R8: blanked region drives black.
    p_blank_black_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !de_out |-> ({red_out, grn_out, blu_out} == '0));

    // R9: strobes leave two clocks after they enter.
    p_de_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt_q == 2'd2) |-> (de_out == $past(de_in, 2)));

    p_hs_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt_q == 2'd2) |-> (hsync_out == $past(hsync_in, 2)));

    p_vs_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt_q == 2'd2) |-> (vsync_out == $past(vsync_in, 2)));

    // R3: without an opaque sprite the background fields form the address.
    p_bg_fallback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_sprite |-> (sel_addr == {bg_pal, bg_cidx}));

    // R2: a chosen sprite never carries the transparent index.
    p_sprite_opaque_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_sprite |-> (sel_addr[CIDX_W-1:0] != '0));

endmodule

bind comp_top comp_top_chk #(
    .CIDX_W (CIDX_W),
    .PAL_W  (PAL_W),
    .CH_W   (CH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bg_cidx    (bg_cidx),
    .bg_pal     (bg_pal),
    .de_in      (de_in),
    .hsync_in   (hsync_in),
    .vsync_in   (vsync_in),
    .red_out    (red_out),
    .grn_out    (grn_out),
    .blu_out    (blu_out),
    .de_out     (de_out),
    .hsync_out  (hsync_out),
    .vsync_out  (vsync_out),
    .sel_sprite (sel_sprite),
    .sel_addr   (sel_addr)
);

// File: tb/tb_comp_top.sv
`timescale 1ns/1ps
module tb_comp_top;

    localparam int NSPR = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bg_cidx = '0;
    logic [2:0]  bg_pal = '0;
    logic [NSPR-1:0]   spr_hit = '0;
    logic [NSPR*3-1:0] spr_cidx = '0;
    logic [NSPR*3-1:0] spr_pal = '0;
    logic        de_in = 1'b0, hsync_in = 1'b0, vsync_in = 1'b0;
    logic        pal_we = 1'b0;
    logic [5:0]  pal_waddr = '0;
    logic [11:0] pal_wdata = '0;
    logic [3:0]  red_out, grn_out, blu_out;
    logic        de_out, hsync_out, vsync_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    comp_top dut (
        .clk(clk), .rst_n(rst_n), .bg_cidx(bg_cidx), .bg_pal(bg_pal),
        .spr_hit(spr_hit), .spr_cidx(spr_cidx), .spr_pal(spr_pal),
        .de_in(de_in), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
        .red_out(red_out), .grn_out(grn_out), .blu_out(blu_out),
        .de_out(de_out), .hsync_out(hsync_out), .vsync_out(vsync_out)
    );

    function automatic logic [11:0] shade(input int a);
        return 12'((a * 67 + 291) % 4096);
    endfunction

    function automatic int slot(input int pal, input int cidx);
        return pal * 8 + cidx;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_sprites();
        spr_hit = '0; spr_cidx = '0; spr_pal = '0;
    endtask

    task automatic set_spr(input int i, input logic hit, input logic [2:0] c, input logic [2:0] p);
        spr_hit[i] = hit;
        spr_cidx[i*3 +: 3] = c;
        spr_pal[i*3 +: 3] = p;
    endtask

    // Inputs already set at a falling edge; sample two clocks later.
    task automatic expect_pix(input string req, input logic [11:0] exp);
        repeat (2) @(negedge clk);
        check(req, {red_out, grn_out, blu_out}, exp);
    endtask

    task automatic host_write(input int a, input logic [11:0] d, input logic we);
        @(negedge clk);
        pal_we = we; pal_waddr = 6'(a); pal_wdata = d;
        @(negedge clk);
        pal_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_black();
        check("R8 reset de_out", de_out, 1'b0);
        clear_sprites();
        de_in = 1'b1; bg_pal = 3'd3; bg_cidx = 3'd5;
        expect_pix("R7 bg slot after reset", 12'h000);
        set_spr(4, 1'b1, 3'd7, 3'd7);
        @(negedge clk);
        expect_pix("R7 sprite slot after reset", 12'h000);
        clear_sprites();
    endtask

    task automatic t_load();
        for (int a = 0; a < 64; a++) host_write(a, shade(a), 1'b1);
        @(negedge clk);
        bg_pal = 3'd2; bg_cidx = 3'd6;
        expect_pix("R6 written colour visible", shade(slot(2, 6)));
        bg_pal = 3'd5; bg_cidx = 3'd1;
        @(negedge clk);
        expect_pix("R5 address and channels", shade(slot(5, 1)));
        check("R5 red field", red_out, shade(slot(5, 1)) >> 8);
        check("R5 blue field", blu_out, shade(slot(5, 1)) & 12'hF);
    endtask

    task automatic t_ignored_write();
        host_write(slot(1, 4), 12'hABC, 1'b0);
        bg_pal = 3'd1; bg_cidx = 3'd4;
        expect_pix("R10 strobe-low write ignored", shade(slot(1, 4)));
    endtask

    task automatic t_priority();
        clear_sprites();
        bg_pal = 3'd0; bg_cidx = 3'd0;
        expect_pix("R3 bg index 0 is a colour", shade(0));
        set_spr(5, 1'b1, 3'd3, 3'd6);
        set_spr(2, 1'b1, 3'd1, 3'd4);
        @(negedge clk);
        expect_pix("R1 lowest opaque wins", shade(slot(4, 1)));
        set_spr(0, 1'b1, 3'd0, 3'd7);
        @(negedge clk);
        expect_pix("R2 transparent sprite skipped", shade(slot(4, 1)));
        set_spr(1, 1'b0, 3'd5, 3'd3);
        @(negedge clk);
        expect_pix("R1 unhit sprite ignored", shade(slot(4, 1)));
        set_spr(2, 1'b1, 3'd0, 3'd4);
        @(negedge clk);
        expect_pix("R2 next opaque shows", shade(slot(6, 3)));
        set_spr(5, 1'b1, 3'd0, 3'd6);
        bg_pal = 3'd7; bg_cidx = 3'd2;
        @(negedge clk);
        expect_pix("R3 all transparent falls back", shade(slot(7, 2)));
        set_spr(7, 1'b1, 3'd6, 3'd1);
        @(negedge clk);
        expect_pix("R4 sprite covers background", shade(slot(1, 6)));
        clear_sprites();
    endtask

    task automatic t_timing();
        @(negedge clk);
        de_in = 1'b1; hsync_in = 1'b0; vsync_in = 1'b0; bg_pal = 3'd6; bg_cidx = 3'd6;
        repeat (3) @(negedge clk);
        de_in = 1'b0; hsync_in = 1'b1; vsync_in = 1'b1;
        @(negedge clk);
        check("R9 de one clock later unchanged", de_out, 1'b1);
        check("R9 colour one clock later unchanged", {red_out, grn_out, blu_out}, shade(slot(6, 6)));
        check("R9 hsync one clock later unchanged", hsync_out, 1'b0);
        de_in = 1'b1; hsync_in = 1'b0; vsync_in = 1'b0;
        @(negedge clk);
        check("R9 de after two clocks", de_out, 1'b0);
        check("R9 hsync after two clocks", hsync_out, 1'b1);
        check("R9 vsync after two clocks", vsync_out, 1'b1);
        check("R8 blank forces black", {red_out, grn_out, blu_out}, 12'h000);
        @(negedge clk);
        check("R9 colour back after blank", {red_out, grn_out, blu_out}, shade(slot(6, 6)));
    endtask

    task automatic t_reset_again();
        do_reset();
        de_in = 1'b1; bg_pal = 3'd2; bg_cidx = 3'd6;
        expect_pix("R7 reset clears loaded entry", 12'h000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_black();
        t_load();
        t_ignored_write();
        t_priority();
        t_timing();
        t_reset_again();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule